// File: doc/BRIEF.md
# Two-Phase Pixel Clock Line Timer

This block produces the horizontal drive timing for a small monochrome LCD panel. It runs from a master clock that is locked to the incoming line rate, nominally 24 MHz. A slot counter divides each line into master-clock slots. From that count the block decodes a line sync pulse, two half-rate pixel clocks with a half-period offset, a white-force flag around the sync pulse, and the index of the pixel being clocked.

The two pixel clocks each run at one eighth of the master clock, giving an effective pixel rate of 6 MHz. Even pixels are clocked on the first phase and odd pixels on the second. The two clocks are built so that they are never high together, with one master cycle of gap on each edge.

When no strobe arrives, the timer free-runs at the nominal line length. A line-start strobe from the sync recovery logic restarts the line at slot 0. All outputs are registered, so the panel sees no glitches.

Top module: `line_pixel_timer`

## Requirements
- R1: While reset is asserted, the outputs are hs=0, ck0=0, ck1=0, white=1 and pix_idx=0. The first clock edge after reset is released shows slot 0.
- R2: With no strobe, the line repeats every 1536 master cycles, and hs is high for slots 0 to 31 of each line.
- R3: When line_start is high at a clock edge, the outputs after that edge show slot 0. This holds for any position in the line and for strobes on consecutive cycles.
- R4: The active window covers slots 96 to 1407 (164 periods of 8 slots). ck0 is high when (slot-96) mod 8 is 0, 1 or 2 inside the active window, and low otherwise.
- R5: ck1 is high when (slot-96) mod 8 is 4, 5 or 6 inside the active window, and low otherwise.
- R6: ck0 and ck1 are never high in the same cycle. Each high pulse that is not cut short by a strobe lasts exactly 3 master cycles.
- R7: Inside the active window, pix_idx = 2*((slot-96) div 8) + (1 if (slot-96) mod 8 is 4 or more). Outside the window pix_idx is 0. ck0 only clocks even indices and ck1 only odd ones, from 0 to 327.
- R8: white is high for slots 0 to 47 and for slots 1520 to 1535, and low otherwise. It is always high while hs is high.
- R9: In a free-running line, the first ck0 rise comes at least 34 cycles after hs falls. The next hs rise comes at least 34 cycles after the last pixel-clock fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | master clock, locked to the line rate |
| rst_n | input | 1 | active-low synchronous reset |
| line_start | input | 1 | line-start strobe; restarts the line at slot 0 |
| hs | output | 1 | line sync pulse |
| ck0 | output | 1 | even-pixel clock |
| ck1 | output | 1 | odd-pixel clock, half a period after ck0 |
| white | output | 1 | forces white video around hs |
| pix_idx | output | 9 | index of the pixel being clocked |

## Verification
The hardest situations to reach are strobes that cut a line short partway through its structure. Examples are a strobe that lands inside a ck0 high pulse, one inside the pre-sync white region, one during hs itself, and strobes on several consecutive cycles. The stimulus follows the expected slot position cycle by cycle and fires line_start exactly at those slots. It then compares every output against the arithmetic slot decode on every cycle around the restart.

// File: rtl/line_pixel_timer.sv
module line_pixel_timer #(
  parameter int LINE_CYC   = 1536,
  parameter int HS_CYC     = 32,
  parameter int ACT_START  = 96,
  parameter int NPIX       = 328,
  parameter int PH_W       = 3,
  parameter int WHITE_PRE  = 16,
  parameter int WHITE_POST = 16,
  parameter int PIX_W      = $clog2(NPIX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_start,
  output logic             hs,
  output logic             ck0,
  output logic             ck1,
  output logic             white,
  output logic [PIX_W-1:0] pix_idx
);
  localparam int TW      = $clog2(LINE_CYC);
  localparam int PIX_CYC = 1 << PH_W;
  localparam int HALF    = PIX_CYC / 2;
  localparam int ACT_END = ACT_START + (NPIX / 2) * PIX_CYC;

  logic [TW-1:0]   tick, tick_nx, rel;
  logic [PH_W-1:0] ph;
  logic            in_act;

  assign tick_nx = (line_start || tick == TW'(LINE_CYC - 1)) ? '0 : tick + 1'b1;
  assign in_act  = (tick_nx >= TW'(ACT_START)) && (tick_nx < TW'(ACT_END));
  assign rel     = tick_nx - TW'(ACT_START);
  assign ph      = rel[PH_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick    <= TW'(LINE_CYC - 1);
      hs      <= 1'b0;
      ck0     <= 1'b0;
      ck1     <= 1'b0;
      white   <= 1'b1;
      pix_idx <= '0;
    end else begin
      tick    <= tick_nx;
      hs      <= tick_nx < TW'(HS_CYC);
      ck0     <= in_act && (ph < PH_W'(HALF - 1));
      ck1     <= in_act && (ph >= PH_W'(HALF)) && (ph < PH_W'(PIX_CYC - 1));
      white   <= (tick_nx < TW'(HS_CYC + WHITE_POST)) || (tick_nx >= TW'(LINE_CYC - WHITE_PRE));
      pix_idx <= in_act ? PIX_W'({rel >> PH_W, ph[PH_W-1]}) : '0;
    end
  end

  assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n) !(ck0 && ck1));
  assert_ck0_width_R4: assert property (@(posedge clk) disable iff (!rst_n || line_start)
    $rose(ck0) |=> ck0 ##1 ck0 ##1 !ck0);
  assert_ck1_width_R5: assert property (@(posedge clk) disable iff (!rst_n || line_start)
    $rose(ck1) |=> ck1 ##1 ck1 ##1 !ck1);
  assert_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> hs && white && !ck0 && !ck1 && pix_idx == '0);
  assert_hs_white_R8: assert property (@(posedge clk) disable iff (!rst_n) hs |-> white);
  assert_even_odd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ck0) |-> !pix_idx[0]) and ($rose(ck1) |-> pix_idx[0]));
  assert_clk_quiet_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hs || white) |-> !(ck0 || ck1));
endmodule

// File: tb/line_pixel_timer_tb.sv
module line_pixel_timer_tb;
  localparam int L = 1536, HSC = 32, AS = 96, NP = 328, ACT = (NP / 2) * 8;

  logic clk = 0, rst_n = 0, line_start = 0;
  logic hs, ck0, ck1, white;
  logic [8:0] pix_idx;
  int total = 0, bad = 0, s = L - 1, cyc = 0;
  bit margin_on = 0;
  int fall_cyc = -1, last_ck_fall = -1;
  bit want_first = 0;
  logic hs_p = 0, ck0_p = 0, ck1_p = 0;

  always #2 clk = ~clk;

  line_pixel_timer u_dut (.clk(clk), .rst_n(rst_n), .line_start(line_start),
    .hs(hs), .ck0(ck0), .ck1(ck1), .white(white), .pix_idx(pix_idx));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s slot=%0d actual=%0d expected=%0d", req, s, act, exp);
    end
  endtask

  task automatic check_slot();
    int rel, ph;
    bit act;
    act = (s >= AS) && (s < AS + ACT);
    rel = s - AS;
    ph  = act ? rel % 8 : 0;
    chk("R2 hs", int'(hs), int'(s < HSC));
    chk("R4 ck0", int'(ck0), int'(act && ph < 3));
    chk("R5 ck1", int'(ck1), int'(act && ph >= 4 && ph < 7));
    chk("R6 overlap", int'(ck0 && ck1), 0);
    chk("R7 pix_idx", int'(pix_idx), act ? 2 * (rel / 8) + (ph >= 4 ? 1 : 0) : 0);
    chk("R8 white", int'(white), int'(s < HSC + 16 || s >= L - 16));
  endtask

  task automatic step(input bit ls);
    line_start = ls;
    @(posedge clk);
    @(negedge clk);
    line_start = 0;
    cyc++;
    s = ls ? 0 : (s + 1) % L;
    check_slot();
    if (ls) chk("R3 restart slot", int'(hs && white && !ck0 && !ck1), 1);
    if (margin_on) begin
      if (hs_p && !hs) begin fall_cyc = cyc; want_first = 1; end
      if (want_first && !ck0_p && ck0) begin
        chk("R9 lead gap>=34", int'(cyc - fall_cyc >= 34), 1);
        want_first = 0;
      end
      if ((ck0_p && !ck0) || (ck1_p && !ck1)) last_ck_fall = cyc;
      if (!hs_p && hs && last_ck_fall >= 0)
        chk("R9 trail gap>=34", int'(cyc - last_ck_fall >= 34), 1);
    end
    hs_p = hs; ck0_p = ck0; ck1_p = ck1;
  endtask

  task automatic run_to(input int target);
    while (s != target) step(0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset hs", int'(hs), 0);
    chk("R1 reset ck0", int'(ck0), 0);
    chk("R1 reset ck1", int'(ck1), 0);
    chk("R1 reset white", int'(white), 1);
    chk("R1 reset pix", int'(pix_idx), 0);
    rst_n = 1;
    step(0);
    chk("R1 first slot zero", int'(hs && !ck0), 1);
    margin_on = 1;
    for (int i = 0; i < 3 * L; i++) step(0);
    chk("R2 line wraps", s, 0);
    margin_on = 0;
    run_to(700);  step(1);
    run_to(5);    step(1);
    run_to(98);   step(1);
    run_to(101);  step(1);
    for (int i = 0; i < 4; i++) step(1);
    run_to(1525); step(1);
    run_to(L - 1); step(1);
    for (int i = 0; i < 2 * L; i++) step(0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #800000;
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule